// File: doc/BRIEF.md
# Exception Vector Entry Unit

This unit decides where a processor core goes when it takes an exception, and keeps the four-bit interrupt mask. An exception request comes with a two-bit kind and a description of where the core was running. That description is made of three bits: whether it was at a lower privilege level, whether that lower level ran 32-bit code, and the stack-select bit. When the unit accepts a request it produces a one-cycle redirect. The redirect target is the software-written vector base plus the offset of one of sixteen 128-byte handler slots.

On entry the unit captures the address of the interrupted instruction and saves the mask as it was before the entry. It then raises every mask bit. An exception-return strobe puts the saved mask back and redirects to the captured address. Software changes the mask through two write strobes that share one four-bit immediate. One strobe ORs the immediate into the mask and the other removes the immediate's bits from it. The immediate value 2 selects the IRQ bit. Pipeline flushing, syndrome decoding and register saving are done elsewhere.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, `mask_q` is 4'b1111, `vbar_q` and `ret_addr` are zero, and `redirect_valid` is low.
- R2: A write with `vbar_we` stores `vbar_wdata` with bits [6:0] forced to zero, and the stored value appears on `vbar_q` in the next cycle.
- R3: An accepted request raises `redirect_valid` for exactly the next cycle. In that cycle `redirect_pc` equals the base held in the request cycle plus group*0x200 plus kind*0x80, taken modulo 2^PC_W.
- R4: The group is taken from the source bits. With `src_lower`=0 it is 0 when `src_sp_sel`=0 and 1 when `src_sp_sel`=1. With `src_lower`=1 it is 2 when `src_is32`=0 and 3 when `src_is32`=1. `src_is32` is ignored when `src_lower`=0, and `src_sp_sel` is ignored when `src_lower`=1.
- R5: `exc_kind` encodes 0 synchronous, 1 IRQ, 2 FIQ and 3 SError, and the kind selects the slot within its group.
- R6: One cycle after an accepted request, `mask_q` is 4'b1111 and `ret_addr` equals the `exc_pc` of the request.
- R7: The mask bits from bit 3 down to bit 0 are debug, SError, IRQ and FIQ. A set write makes the mask mask|imm, and a clear write makes it mask&~imm. When both strobes are high in the same cycle, the result is (mask|imm)&~imm. The immediate 4'b0010 selects the IRQ bit.
- R8: An IRQ request (kind 1) is refused while `mask_q[1]`=1. A refused request causes no redirect and leaves `ret_addr` unchanged. Other kinds are accepted whatever the mask holds.
- R9: An `eret` strobe that follows an entry restores `mask_q` to the value it had just before that entry. In the next cycle it pulses `redirect_valid` with `redirect_pc` equal to `ret_addr`.
- R10: An `eret` strobe with no entry outstanding, including a second strobe after a return, causes no redirect and leaves the mask unchanged.
- R11: When a request is accepted, an `eret` or mask write in the same cycle is dropped. A base write in that cycle is stored, but the redirect uses the previous base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request strobe |
| exc_kind | input | 2 | Exception kind (0 sync, 1 IRQ, 2 FIQ, 3 SError) |
| src_lower | input | 1 | Request comes from a lower privilege level |
| src_is32 | input | 1 | The lower level was running 32-bit code |
| src_sp_sel | input | 1 | Stack-select bit at the current level |
| exc_pc | input | PC_W | Address of the interrupted instruction |
| eret | input | 1 | Exception-return strobe |
| vbar_we | input | 1 | Vector base write strobe |
| vbar_wdata | input | PC_W | Vector base write data |
| mask_set_we | input | 1 | OR the immediate into the mask |
| mask_clr_we | input | 1 | Clear the immediate's bits from the mask |
| mask_imm | input | 4 | Mask immediate |
| redirect_valid | output | 1 | Redirect strobe |
| redirect_pc | output | PC_W | Redirect target |
| mask_q | output | 4 | Current mask {debug, SError, IRQ, FIQ} |
| ret_addr | output | PC_W | Captured return address |
| vbar_q | output | PC_W | Current vector base |

## Verification
The bench builds the unit with its default PC_W of 32, so all addresses are 32 bits wide. With a base set to 0xFFFF_FF80, the last slot (group 3, SError, offset 0x780) wraps around to 0x0000_0700, which exercises the modulo addition of R3. The 32-bit width also lets the bench walk all sixteen slots and check each target as an exact value. It further drives the source bits that the group decode ignores to their opposite values, and stacks a base write, mask writes and a return onto the same cycle as an accepted entry.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    localparam int unsigned MASK_W      = 4;
    localparam int unsigned SLOT_SHIFT  = 7;
    localparam int unsigned OFFSET_W    = 11;

    typedef enum logic [1:0] {
        KIND_SYNC = 2'd0,
        KIND_IRQ  = 2'd1,
        KIND_FIQ  = 2'd2,
        KIND_SERR = 2'd3
    } exc_kind_e;

    typedef enum logic [1:0] {
        SRC_CUR_SHARED = 2'd0,
        SRC_CUR_OWN    = 2'd1,
        SRC_LOW_64     = 2'd2,
        SRC_LOW_32     = 2'd3
    } exc_src_e;

    typedef struct packed {
        logic dbg;
        logic serr;
        logic irq;
        logic fiq;
    } mask_t;

    localparam mask_t MASK_ALL = '{dbg: 1'b1, serr: 1'b1, irq: 1'b1, fiq: 1'b1};

    function automatic exc_src_e classify_src(input logic lower,
                                              input logic is32,
                                              input logic sp_sel);
        if (lower)
            return is32 ? SRC_LOW_32 : SRC_LOW_64;
        return sp_sel ? SRC_CUR_OWN : SRC_CUR_SHARED;
    endfunction

    function automatic logic [OFFSET_W-1:0] slot_offset(input exc_src_e src,
                                                        input exc_kind_e kind);
        return {src, kind, {SLOT_SHIFT{1'b0}}};
    endfunction

    function automatic mask_t apply_mask_write(input mask_t cur,
                                               input logic set_we,
                                               input logic clr_we,
                                               input logic [MASK_W-1:0] imm);
        logic [MASK_W-1:0] v;
        v = cur;
        if (set_we) v = v | imm;
        if (clr_we) v = v & ~imm;
        return mask_t'(v);
    endfunction

endpackage

// File: rtl/exc_slot_calc.sv
module exc_slot_calc
    import exc_vec_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0] base,
    input  exc_src_e        src,
    input  exc_kind_e       kind,
    output logic [PC_W-1:0] target
);

    logic [OFFSET_W-1:0] off;

    always_comb off = slot_offset(src, kind);

    generate
        if (PC_W > OFFSET_W) begin : g_wide
            always_comb target = base + {{(PC_W-OFFSET_W){1'b0}}, off};
        end else begin : g_narrow
            always_comb target = base + off[PC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/exc_mask_ctrl.sv
module exc_mask_ctrl
    import exc_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              restore,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [MASK_W-1:0] imm,
    output mask_t             mask_q
);

    mask_t saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= MASK_ALL;
            saved_q <= MASK_ALL;
        end else if (take) begin
            saved_q <= mask_q;
            mask_q  <= MASK_ALL;
        end else if (restore) begin
            mask_q  <= saved_q;
        end else begin
            mask_q  <= apply_mask_write(mask_q, set_we, clr_we, imm);
        end
    end

endmodule

// File: rtl/exc_return_ctrl.sv
module exc_return_ctrl #(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            eret,
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] ret_addr_q,
    output logic            pend_q,
    output logic            ret_fire
);

    always_comb ret_fire = eret && pend_q && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_addr_q <= '0;
            pend_q     <= 1'b0;
        end else if (take) begin
            ret_addr_q <= pc_in;
            pend_q     <= 1'b1;
        end else if (ret_fire) begin
            pend_q     <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_vec_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_req,
    input  logic [1:0]      exc_kind,
    input  logic            src_lower,
    input  logic            src_is32,
    input  logic            src_sp_sel,
    input  logic [PC_W-1:0] exc_pc,
    input  logic            eret,
    input  logic            vbar_we,
    input  logic [PC_W-1:0] vbar_wdata,
    input  logic            mask_set_we,
    input  logic            mask_clr_we,
    input  logic [3:0]      mask_imm,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic [3:0]      mask_q,
    output logic [PC_W-1:0] ret_addr,
    output logic [PC_W-1:0] vbar_q
);

    localparam logic [PC_W-1:0] ALIGN_KEEP = ~PC_W'((1 << SLOT_SHIFT) - 1);

    exc_kind_e       kind;
    exc_src_e        src;
    mask_t           mask_s;
    logic            take;
    logic            ret_fire;
    logic            pend_q;
    logic [PC_W-1:0] slot_pc;

    always_comb begin
        kind = exc_kind_e'(exc_kind);
        src  = classify_src(src_lower, src_is32, src_sp_sel);
        take = exc_req && !(kind == KIND_IRQ && mask_s.irq);
    end

    exc_slot_calc #(.PC_W(PC_W)) slot_i (
        .base   (vbar_q),
        .src    (src),
        .kind   (kind),
        .target (slot_pc)
    );

    exc_mask_ctrl mask_i (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .restore (ret_fire),
        .set_we  (mask_set_we),
        .clr_we  (mask_clr_we),
        .imm     (mask_imm),
        .mask_q  (mask_s)
    );

    exc_return_ctrl #(.PC_W(PC_W)) ret_i (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .eret       (eret),
        .pc_in      (exc_pc),
        .ret_addr_q (ret_addr),
        .pend_q     (pend_q),
        .ret_fire   (ret_fire)
    );

    always_comb mask_q = mask_s;

    always_ff @(posedge clk) begin
        if (rst)
            vbar_q <= '0;
        else if (vbar_we)
            vbar_q <= vbar_wdata & ALIGN_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else if (take) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= slot_pc;
        end else if (ret_fire) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= ret_addr;
        end else begin
            redirect_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            exc_req,
    input logic [1:0]      exc_kind,
    input logic            src_lower,
    input logic            src_is32,
    input logic            src_sp_sel,
    input logic [PC_W-1:0] exc_pc,
    input logic            eret,
    input logic            mask_set_we,
    input logic            mask_clr_we,
    input logic [3:0]      mask_imm,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc,
    input logic [3:0]      mask_q,
    input logic [PC_W-1:0] ret_addr,
    input logic [PC_W-1:0] vbar_q,
    input logic            pend
);

    logic            acc;
    logic [1:0]      grp;
    logic [PC_W-1:0] exp_pc;

    always_comb begin
        acc    = exc_req && !(exc_kind == 2'd1 && mask_q[1]);
        grp    = src_lower ? (src_is32 ? 2'd3 : 2'd2) : (src_sp_sel ? 2'd1 : 2'd0);
        exp_pc = vbar_q + PC_W'(32'(grp) * 32'h200 + 32'(exc_kind) * 32'h80);
    end

    p_vbar_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        vbar_q[6:0] == 7'd0);

    p_redirect_slot_r3: assert property (@(posedge clk) disable iff (rst)
        acc |=> redirect_valid && redirect_pc == $past(exp_pc));

    p_entry_masks_r6: assert property (@(posedge clk) disable iff (rst)
        acc |=> mask_q == 4'hF);

    p_entry_retaddr_r6: assert property (@(posedge clk) disable iff (rst)
        acc |=> ret_addr == $past(exc_pc));

    p_set_write_r7: assert property (@(posedge clk) disable iff (rst)
        (!acc && !(eret && pend) && mask_set_we && !mask_clr_we)
        |=> mask_q == ($past(mask_q) | $past(mask_imm)));

    p_irq_refused_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_kind == 2'd1 && mask_q[1] && !eret) |=> !redirect_valid);

    p_eret_target_r9: assert property (@(posedge clk) disable iff (rst)
        (eret && pend && !acc) |=> redirect_valid && redirect_pc == $past(ret_addr));

    p_eret_orphan_r10: assert property (@(posedge clk) disable iff (rst)
        (eret && !pend && !exc_req && !mask_set_we && !mask_clr_we)
        |=> !redirect_valid && $stable(mask_q));

endmodule

bind exc_vector_unit exc_vector_unit_chk #(.PC_W(PC_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .exc_req        (exc_req),
    .exc_kind       (exc_kind),
    .src_lower      (src_lower),
    .src_is32       (src_is32),
    .src_sp_sel     (src_sp_sel),
    .exc_pc         (exc_pc),
    .eret           (eret),
    .mask_set_we    (mask_set_we),
    .mask_clr_we    (mask_clr_we),
    .mask_imm       (mask_imm),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .mask_q         (mask_q),
    .ret_addr       (ret_addr),
    .vbar_q         (vbar_q),
    .pend           (pend_q)
);

// File: tb/exc_vector_unit_tb_top.sv
module exc_vector_unit_tb_top;

    localparam int unsigned PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            exc_req = 1'b0;
    logic [1:0]      exc_kind = 2'd0;
    logic            src_lower = 1'b0;
    logic            src_is32 = 1'b0;
    logic            src_sp_sel = 1'b0;
    logic [PC_W-1:0] exc_pc = '0;
    logic            eret = 1'b0;
    logic            vbar_we = 1'b0;
    logic [PC_W-1:0] vbar_wdata = '0;
    logic            mask_set_we = 1'b0;
    logic            mask_clr_we = 1'b0;
    logic [3:0]      mask_imm = 4'd0;
    logic            redirect_valid;
    logic [PC_W-1:0] redirect_pc;
    logic [3:0]      mask_q;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] vbar_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exc_vector_unit #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind),
        .src_lower(src_lower), .src_is32(src_is32), .src_sp_sel(src_sp_sel),
        .exc_pc(exc_pc), .eret(eret), .vbar_we(vbar_we), .vbar_wdata(vbar_wdata),
        .mask_set_we(mask_set_we), .mask_clr_we(mask_clr_we), .mask_imm(mask_imm),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .mask_q(mask_q), .ret_addr(ret_addr), .vbar_q(vbar_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] want_pc(input logic [PC_W-1:0] base,
                                                input int grp, input int kind);
        return base + PC_W'(grp * 'h200 + kind * 'h80);
    endfunction

    task automatic idle_inputs();
        exc_req = 0; eret = 0; vbar_we = 0; mask_set_we = 0; mask_clr_we = 0;
    endtask

    task automatic write_base(input logic [PC_W-1:0] v);
        vbar_we = 1; vbar_wdata = v;
        @(negedge clk); idle_inputs();
    endtask

    task automatic mask_write(input logic s, input logic c, input logic [3:0] imm);
        mask_set_we = s; mask_clr_we = c; mask_imm = imm;
        @(negedge clk); idle_inputs();
    endtask

    task automatic fire(input int kind, input logic lo, input logic is32,
                        input logic sp, input logic [PC_W-1:0] pc);
        exc_req = 1; exc_kind = 2'(kind); src_lower = lo; src_is32 = is32;
        src_sp_sel = sp; exc_pc = pc;
        @(negedge clk); idle_inputs();
    endtask

    task automatic do_eret();
        eret = 1;
        @(negedge clk); idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1 mask after reset", 64'(mask_q), 64'hF);
        chk("R1 base after reset", 64'(vbar_q), 64'h0);
        chk("R1 ret after reset", 64'(ret_addr), 64'h0);
        chk("R1 redirect after reset", 64'(redirect_valid), 64'h0);
    endtask

    task automatic t_base();
        write_base(32'h1234_56FF);
        chk("R2 base low bits cleared", 64'(vbar_q), 64'h1234_5680);
    endtask

    task automatic t_mask_writes();
        mask_write(0, 1, 4'b0010);
        chk("R7 clear IRQ bit", 64'(mask_q), 64'hD);
        mask_write(0, 1, 4'hF);
        chk("R7 clear all", 64'(mask_q), 64'h0);
        mask_write(1, 0, 4'b0010);
        chk("R7 set IRQ bit", 64'(mask_q), 64'h2);
        mask_write(1, 1, 4'b0100);
        chk("R7 set and clear same cycle", 64'(mask_q), 64'h2);
        mask_write(0, 1, 4'b0010);
        chk("R7 mask open", 64'(mask_q), 64'h0);
    endtask

    task automatic t_all_slots();
        logic [PC_W-1:0] base = vbar_q;
        for (int g = 0; g < 4; g++) begin
            for (int k = 0; k < 4; k++) begin
                logic lo = (g >= 2);
                logic is32 = (g == 3) || (g < 2);
                logic sp = (g == 1) || (g == 2);
                logic [PC_W-1:0] pc = 32'h8000_0000 + PC_W'(g * 16 + k * 4);
                fire(k, lo, is32, sp, pc);
                chk($sformatf("R3 R4 R5 redirect valid g%0d k%0d", g, k), 64'(redirect_valid), 64'h1);
                chk($sformatf("R3 R4 R5 slot pc g%0d k%0d", g, k), 64'(redirect_pc), 64'(want_pc(base, g, k)));
                chk("R6 mask raised", 64'(mask_q), 64'hF);
                chk("R6 return address", 64'(ret_addr), 64'(pc));
                @(negedge clk);
                chk("R3 redirect single cycle", 64'(redirect_valid), 64'h0);
                do_eret();
                chk("R9 return redirect", 64'(redirect_valid), 64'h1);
                chk("R9 return target", 64'(redirect_pc), 64'(pc));
                chk("R9 mask restored", 64'(mask_q), 64'h0);
            end
        end
    endtask

    task automatic t_irq_masked();
        logic [PC_W-1:0] old_ret = ret_addr;
        mask_write(1, 0, 4'b0010);
        fire(1, 0, 0, 1, 32'hDEAD_0000);
        chk("R8 masked IRQ no redirect", 64'(redirect_valid), 64'h0);
        chk("R8 masked IRQ mask kept", 64'(mask_q), 64'h2);
        chk("R8 masked IRQ ret kept", 64'(ret_addr), 64'(old_ret));
        fire(2, 0, 0, 1, 32'h0000_4444);
        chk("R8 FIQ taken with IRQ masked", 64'(redirect_valid), 64'h1);
        chk("R8 FIQ slot", 64'(redirect_pc), 64'(want_pc(vbar_q, 1, 2)));
        do_eret();
        chk("R9 mask back to IRQ-only", 64'(mask_q), 64'h2);
    endtask

    task automatic t_orphan_eret();
        do_eret();
        chk("R10 orphan eret no redirect", 64'(redirect_valid), 64'h0);
        chk("R10 orphan eret mask kept", 64'(mask_q), 64'h2);
    endtask

    task automatic t_collision();
        logic [PC_W-1:0] old_base = vbar_q;
        mask_write(0, 1, 4'hF);
        exc_req = 1; exc_kind = 2'd0; src_lower = 1; src_is32 = 0; src_sp_sel = 0;
        exc_pc = 32'h0000_1230; eret = 1; vbar_we = 1; vbar_wdata = 32'h0004_0000;
        mask_set_we = 1; mask_imm = 4'b0001;
        @(negedge clk); idle_inputs();
        chk("R11 redirect uses old base", 64'(redirect_pc), 64'(want_pc(old_base, 2, 0)));
        chk("R11 mask write dropped", 64'(mask_q), 64'hF);
        chk("R11 new base stored", 64'(vbar_q), 64'h0004_0000);
        do_eret();
        chk("R11 eret still pending", 64'(redirect_pc), 64'h0000_1230);
        chk("R11 saved mask unaffected", 64'(mask_q), 64'h0);
    endtask

    task automatic t_wrap();
        write_base(32'hFFFF_FF80);
        fire(3, 1, 1, 0, 32'h0000_0F00);
        chk("R3 wrapped slot address", 64'(redirect_pc), 64'h0000_0700);
        do_eret();
        chk("R9 return after wrap", 64'(redirect_pc), 64'h0000_0F00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_base();
        t_mask_writes();
        t_all_slots();
        t_irq_masked();
        t_orphan_eret();
        t_collision();
        t_wrap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule